// File: doc/BRIEF.md
# Status-Flag Conditional Branch Resolver

This block settles a conditional relative branch for an 8-bit microcontroller core. Each cycle it receives the current program counter, a signed relative displacement, a selector that picks one of the eight status-register bits, a polarity bit and the status register itself. From these it decides whether the branch is taken. It then produces the program counter of the next instruction and the number of clock cycles the branch costs.

A single generic unit covers all of the flag-conditioned branches. The core picks the bit and asks whether that bit must be set or clear. Branches on the global interrupt enable, the transfer bit and the overflow bit are three selector values of this one path, not separate logic. The status register passes through the block untouched so that downstream logic can see that no flag was altered. All outputs are registered and appear one clock after their inputs.

Top module: `flag_branch_resolver`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs become `next_pc_o` = 0, `taken_o` = 0, `cost_o` = 1 and `sreg_o` = 0.
- R2: The branch is taken when bit `sel_i` of `sreg_i` equals `pol_i`. With `pol_i` = 1 it branches when the bit is set, and with `pol_i` = 0 when the bit is clear. The bit order from bit 7 down to bit 0 is I, T, H, S, V, N, Z, C, so `sel_i` = 7 selects I, 6 selects T and 3 selects V.
- R3: When the branch is taken, `next_pc_o` = `pc_i` + sign-extended `ofs_i` + 1. `ofs_i` is a 7-bit two's-complement value in the range -64..+63.
- R4: When the branch is not taken, `next_pc_o` = `pc_i` + 1.
- R5: Program-counter arithmetic wraps modulo 2^`PC_W` in both directions.
- R6: `cost_o` is 2 when the branch is taken and 1 when it is not.
- R7: `sreg_o` equals the `sreg_i` sampled at the same edge; the block modifies no flag.
- R8: Outputs reflect the inputs sampled at the previous rising edge and hold between edges.
- R9: Status bits other than the selected one have no effect on `taken_o`, `next_pc_o` or `cost_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 16 | Address of the branch instruction |
| ofs_i | input | 7 | Signed relative displacement |
| sel_i | input | 3 | Index of the status bit to test |
| pol_i | input | 1 | 1: branch if bit set, 0: branch if bit clear |
| sreg_i | input | 8 | Status register |
| next_pc_o | output | 16 | Address of the next instruction |
| taken_o | output | 1 | Branch taken |
| cost_o | output | 2 | Cycles consumed by the branch |
| sreg_o | output | 8 | Status register, passed through unchanged |

## Verification
The main sweep covers every selector value with both polarities and both values of the tested bit. It runs once with a positive displacement and once with a negative one, so a wrong bit index, an inverted polarity or a missing sign extension each give a distinct wrong target. Status words that hold the selected bit fixed while every other bit is flipped separate a correct single-bit test from one that leaks neighbouring flags. Addresses at the bottom and top of program memory, paired with displacements at both extremes, expose a carry that should wrap but does not.

// File: rtl/flag_branch_pkg.sv
// Package: shared widths and branch-cost constants for the resolver.
// Assumes an 8-bit status register and a 7-bit signed displacement.
package flag_branch_pkg;
    localparam int SREG_W     = 8;
    localparam int SEL_W      = $clog2(SREG_W);
    localparam int OFS_W      = 7;
    localparam int COST_W     = 2;
    localparam logic [COST_W-1:0] COST_TAKEN = 2'd2;
    localparam logic [COST_W-1:0] COST_FALL  = 2'd1;

    // Named positions of the status bits, used by callers and the bench.
    typedef enum logic [SEL_W-1:0] {
        FLAG_C = 3'd0, FLAG_Z = 3'd1, FLAG_N = 3'd2, FLAG_V = 3'd3,
        FLAG_S = 3'd4, FLAG_H = 3'd5, FLAG_T = 3'd6, FLAG_I = 3'd7
    } flag_pos_e;
endpackage

// File: rtl/flag_condition.sv
// Module: flag_condition
// Decides whether a branch is taken by comparing one chosen status bit with
// a requested polarity. Purely combinational; assumes sel indexes a valid bit.
module flag_condition #(
    parameter int SREG_W = 8,
    localparam int SEL_W = $clog2(SREG_W)
) (
    input  logic [SREG_W-1:0] sreg,
    input  logic [SEL_W-1:0]  sel,
    input  logic              pol,
    output logic              take
);
    logic [SREG_W-1:0] match;

    // One comparator per status bit: high when that bit equals the polarity.
    for (genvar b = 0; b < SREG_W; b++) begin : g_match
        assign match[b] = (sreg[b] == pol);
    end

    // Pick the comparison for the selected bit only.
    always_comb begin
        take = match[sel];
    end
endmodule

// File: rtl/branch_target.sv
// Module: branch_target
// Computes both candidate next addresses: the fall-through (pc + 1) and the
// relative target (pc + sign-extended offset + 1). Arithmetic wraps at PC_W.
module branch_target #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 7
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  pc_fall,
    output logic [PC_W-1:0]  pc_jump
);
    localparam int EXT_W = PC_W - OFS_W;

    logic [PC_W-1:0] ofs_ext;

    // Sign-extend the displacement to the program-counter width.
    always_comb begin
        ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    end

    // Form both addresses; the carry out of PC_W bits is dropped (wrap).
    always_comb begin
        pc_fall = pc + PC_W'(1);
        pc_jump = pc_fall + ofs_ext;
    end
endmodule

// File: rtl/flag_branch_resolver.sv
// Module: flag_branch_resolver (top)
// Resolves a flag-conditioned relative branch: chooses the next PC, flags
// whether the branch is taken and reports its cycle cost. Outputs are
// registered (one-cycle latency). The status register passes through as-is.
// Assumes inputs are stable around the rising edge; reset is synchronous.
module flag_branch_resolver
    import flag_branch_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              pol_i,
    input  logic [SREG_W-1:0] sreg_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o,
    output logic [COST_W-1:0] cost_o,
    output logic [SREG_W-1:0] sreg_o
);
    logic            take_c;
    logic [PC_W-1:0] pc_fall_c;
    logic [PC_W-1:0] pc_jump_c;

    flag_condition #(.SREG_W(SREG_W)) u_cond (
        .sreg (sreg_i),
        .sel  (sel_i),
        .pol  (pol_i),
        .take (take_c)
    );

    branch_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
        .pc      (pc_i),
        .ofs     (ofs_i),
        .pc_fall (pc_fall_c),
        .pc_jump (pc_jump_c)
    );

    // Register the decision, chosen address, cost and untouched flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o <= '0;
            taken_o   <= 1'b0;
            cost_o    <= COST_FALL;
            sreg_o    <= '0;
        end else begin
            next_pc_o <= take_c ? pc_jump_c : pc_fall_c;
            taken_o   <= take_c;
            cost_o    <= take_c ? COST_TAKEN : COST_FALL;
            sreg_o    <= sreg_i;
        end
    end
endmodule

// File: rtl/flag_branch_resolver_chk.sv
// Module: flag_branch_resolver_chk
// Temporal checks on the resolver's ports, attached with bind below.
module flag_branch_resolver_chk
    import flag_branch_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              pol_i,
    input  logic [SREG_W-1:0] sreg_i,
    input  logic [PC_W-1:0]   next_pc_o,
    input  logic              taken_o,
    input  logic [COST_W-1:0] cost_o,
    input  logic [SREG_W-1:0] sreg_o
);
    logic            chosen_bit;
    logic [PC_W-1:0] want_jump;
    logic [PC_W-1:0] want_fall;

    // Reference values formed from the inputs for the next-cycle checks.
    always_comb begin
        chosen_bit = sreg_i[sel_i];
        want_fall  = pc_i + PC_W'(1);
        want_jump  = pc_i + PC_W'(signed'(ofs_i)) + PC_W'(1);
    end

    // R2: the decision follows the chosen bit and polarity.
    p_decide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (taken_o == ($past(chosen_bit) == $past(pol_i))));

    // R3: a taken branch lands on pc + offset + 1.
    p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (!taken_o || next_pc_o == $past(want_jump)));

    // R4: a branch that is not taken moves to pc + 1.
    p_fall_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (taken_o || next_pc_o == $past(want_fall)));

    // R6: the cost agrees with the decision.
    p_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cost_o == (taken_o ? COST_TAKEN : COST_FALL));

    // R7: flags come out exactly as they went in.
    p_flags_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sreg_o == $past(sreg_i)));
endmodule

bind flag_branch_resolver flag_branch_resolver_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/flag_branch_resolver_tb.sv
// Directed bench for flag_branch_resolver: one task per scenario.
module flag_branch_resolver_tb;
    localparam int PC_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [PC_W-1:0]   pc_i;
    logic [6:0]        ofs_i;
    logic [2:0]        sel_i;
    logic              pol_i;
    logic [7:0]        sreg_i;
    logic [PC_W-1:0]   next_pc_o;
    logic              taken_o;
    logic [1:0]        cost_o;
    logic [7:0]        sreg_o;

    int checks = 0;
    int errors = 0;

    flag_branch_resolver #(.PC_W(PC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .ofs_i(ofs_i), .sel_i(sel_i),
        .pol_i(pol_i), .sreg_i(sreg_i), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .cost_o(cost_o), .sreg_o(sreg_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one branch, wait for the capturing edge and compare all outputs.
    task automatic apply(input string req, input logic [PC_W-1:0] pc,
                         input logic [6:0] ofs, input logic [2:0] sel,
                         input logic pol, input logic [7:0] sreg);
        logic            e_take;
        logic [PC_W-1:0] e_pc;
        @(negedge clk);
        pc_i = pc; ofs_i = ofs; sel_i = sel; pol_i = pol; sreg_i = sreg;
        e_take = (sreg[sel] == pol);
        e_pc   = e_take ? pc + {{(PC_W-7){ofs[6]}}, ofs} + 16'd1 : pc + 16'd1;
        @(posedge clk); #2;
        check(req, "taken", 32'(taken_o), 32'(e_take));
        check(req, "next_pc", 32'(next_pc_o), 32'(e_pc));
        check("R6", "cost", 32'(cost_o), e_take ? 32'd2 : 32'd1);
        check("R7", "sreg", 32'(sreg_o), 32'(sreg));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        pc_i = 16'h1234; ofs_i = 7'h05; sel_i = 3'd0; pol_i = 1'b1; sreg_i = 8'hFF;
        repeat (2) @(posedge clk);
        #2;
        check("R1", "reset next_pc", 32'(next_pc_o), 32'd0);
        check("R1", "reset taken", 32'(taken_o), 32'd0);
        check("R1", "reset cost", 32'(cost_o), 32'd1);
        check("R1", "reset sreg", 32'(sreg_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2/R3/R4: every bit, both polarities, both bit values, both offset signs.
    task automatic t_sweep();
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 2; p++) begin
                for (int v = 0; v < 2; v++) begin
                    logic [7:0] sr;
                    sr = v[0] ? (8'h01 << s) : ~(8'h01 << s);
                    apply("R2_R3_R4", 16'h0400 + 16'(s * 4), 7'h15, 3'(s), p[0], sr);
                    apply("R2_R3_R4", 16'h0800 + 16'(s * 4), 7'h6B, 3'(s), p[0], sr);
                end
            end
        end
    endtask

    // R2: named flags I (7), T (6) and V (3).
    task automatic t_named();
        apply("R2", 16'h0100, 7'h10, 3'd7, 1'b1, 8'h80);
        apply("R2", 16'h0100, 7'h10, 3'd7, 1'b0, 8'h80);
        apply("R2", 16'h0200, 7'h7F, 3'd6, 1'b0, 8'h00);
        apply("R2", 16'h0300, 7'h01, 3'd3, 1'b1, 8'h08);
    endtask

    // R3/R5: offset extremes and wrap at both ends of memory.
    task automatic t_wrap();
        apply("R3", 16'h1000, 7'h3F, 3'd0, 1'b1, 8'h01);
        apply("R3", 16'h1000, 7'h40, 3'd0, 1'b1, 8'h01);
        apply("R5", 16'hFFF0, 7'h3F, 3'd1, 1'b1, 8'h02);
        apply("R5", 16'h0005, 7'h40, 3'd1, 1'b1, 8'h02);
        apply("R5", 16'hFFFF, 7'h00, 3'd1, 1'b0, 8'h02);
        apply("R5", 16'hFFFF, 7'h7F, 3'd2, 1'b1, 8'h04);
    endtask

    // R9: flip every non-selected bit; the result must not move.
    task automatic t_isolation();
        for (int s = 0; s < 8; s++) begin
            logic [7:0] m;
            m = 8'h01 << s;
            apply("R9", 16'h2000, 7'h22, 3'(s), 1'b1, m);
            apply("R9", 16'h2000, 7'h22, 3'(s), 1'b1, 8'hFF);
            apply("R9", 16'h2000, 7'h22, 3'(s), 1'b0, 8'hFF & ~m);
            apply("R9", 16'h2000, 7'h22, 3'(s), 1'b0, 8'h00);
        end
    endtask

    // R8: outputs hold the previous edge's result until the next edge.
    task automatic t_latency();
        apply("R8", 16'h3000, 7'h08, 3'd4, 1'b1, 8'h10);
        @(negedge clk);
        pc_i = 16'h5000; sel_i = 3'd4; pol_i = 1'b0; sreg_i = 8'h10;
        #1;
        check("R8", "held next_pc", 32'(next_pc_o), 32'h3009);
        check("R8", "held taken", 32'(taken_o), 32'd1);
        @(posedge clk); #2;
        check("R8", "updated next_pc", 32'(next_pc_o), 32'h5001);
        check("R8", "updated taken", 32'(taken_o), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_named();
        t_wrap();
        t_isolation();
        t_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule